// File: doc/BRIEF.md
# Port Quadlet Packer and Unpacker

This block sits between an external parallel transfer port and a packet path that works in 32-bit quadlets. On the transmit side it gathers port fetches into quadlets. In doublet mode each fetch is 16 bits and two fetches make a quadlet. In byte mode each fetch is 8 bits and four fetches make a quadlet. It emits each finished quadlet with a one-cycle valid pulse. On the receive side it takes a quadlet and plays it back onto the port one doublet or one byte per cycle, and it drives a per-lane output enable.

A start-of-packet strobe clears the packing position. It is also the only moment at which the byte-mode and swap controls are taken. Those controls then stay fixed for the whole packet. The swap option reverses all four bytes of a quadlet, and the same rule applies in both directions. Byte mode is allowed only at the two slowest speed codes. At start of packet the block raises a configuration error flag if byte mode is combined with a faster code.

Top module: `qpack_top`

## Requirements
- R1: In doublet mode (byte mode clear), two accepted fetches form a quadlet with the first fetch in bits 31:16 and the second in bits 15:0. Fetches 16'hAB01 then 16'hCD02 give 32'hAB01CD02.
- R2: With swap set, the stacked quadlet is byte-reversed. The byte in bits 7:0 moves to bits 31:24, and so on. In doublet mode AB01, CD02 gives 32'h02CD01AB, and in byte mode AB, 01, CD, 02 gives the same value.
- R3: In byte mode, four accepted fetches form a quadlet, and the first one lands in bits 31:24. Only port bits 7:0 are sampled, and bits 15:8 have no effect on the result.
- R4: `quad_vld_o` is high for exactly one cycle. It is set by the clock edge that captures the final fetch of a quadlet, and `quad_o` holds its value until the next quadlet completes.
- R5: `sop_i` resets the packing position, so a partly filled quadlet is discarded. A fetch that arrives in the same cycle as `sop_i` is taken as the first fetch of the new packet, under the controls presented with `sop_i`.
- R6: `byte_mode_i` and `swap_i` are sampled only while `sop_i` is high. Changing them mid-packet has no effect until the next `sop_i`.
- R7: Speed codes are 0 and 1 (slow classes, up to 200 Mbps) and 2 and 3 (faster classes). On each `sop_i`, `cfg_err_o` is updated to 1 if byte mode is selected with a code above 1, and to 0 otherwise.
- R8: While idle, `quad_load_i` accepts `quad_i`. The value is byte-reversed first if swap is in effect. From the next cycle the quadlet is emitted most significant part first on `port_d_o`, with `port_stb_o` high: two doublets in doublet mode, or four bytes in byte mode.
- R9: During unpacking, `port_oe_o[0]` enables lanes 7:0 and `port_oe_o[1]` enables lanes 15:8. In doublet mode both bits are high. In byte mode only bit 0 is high, and `port_d_o[15:8]` is zero. When idle, both bits and `port_d_o` are zero.
- R10: A `quad_load_i` that arrives while an unpack is in progress is ignored, and the sequence in progress runs on unchanged.
- R11: After `rst_ni` is deasserted, all outputs are zero and the default controls are doublet mode with swap clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sop_i | input | 1 | Start of packet: clears the packing position and samples the controls |
| byte_mode_i | input | 1 | 1 selects 8-bit fetches, 0 selects 16-bit fetches |
| swap_i | input | 1 | 1 byte-reverses each quadlet |
| speed_i | input | 2 | Speed code, checked against byte mode |
| port_d_i | input | 16 | Port data for transmit |
| port_vld_i | input | 1 | A port fetch is present |
| quad_o | output | 32 | Packed quadlet |
| quad_vld_o | output | 1 | One-cycle pulse when a quadlet completes |
| cfg_err_o | output | 1 | Byte mode combined with a speed code that is too fast |
| quad_i | input | 32 | Quadlet to unpack |
| quad_load_i | input | 1 | Load `quad_i` for unpacking |
| port_d_o | output | 16 | Port data for receive |
| port_oe_o | output | 2 | Output enable for the lower and upper byte lanes |
| port_stb_o | output | 1 | `port_d_o` carries a valid doublet or byte |

## Verification
A start-of-packet strobe and a port fetch can arrive in the same cycle. The bench provokes this by raising `sop_i` together with `port_vld_i` while a quadlet is half filled, with the controls changed at the same moment. The result is judged by two checks. First, no quadlet pulse may appear at that edge. Second, the next quadlet must begin with that fetch and follow the newly presented mode. The bench also drives a load while an unpack is in progress and judges the outcome by the port sequence that follows.

// File: rtl/qpack_pkg.sv
package qpack_pkg;
  localparam int unsigned LANE_W       = 8;
  localparam int unsigned PORT_LANES   = 2;
  localparam int unsigned QUAD_LANES   = 4;
  localparam int unsigned PORT_W       = LANE_W * PORT_LANES;
  localparam int unsigned QUAD_W       = LANE_W * QUAD_LANES;
  localparam int unsigned SPD_W        = 2;
  localparam int unsigned BYTE_SPD_MAX = 1;
  localparam int unsigned CNT_W        = $clog2(QUAD_LANES);
  localparam int unsigned REM_W        = $clog2(QUAD_LANES + 1);
  localparam int unsigned DBL_PER_QUAD = QUAD_LANES / PORT_LANES;

  function automatic logic [QUAD_W-1:0] lane_rev(input logic [QUAD_W-1:0] q);
    logic [QUAD_W-1:0] r;
    for (int i = 0; i < QUAD_LANES; i++)
      r[i*LANE_W +: LANE_W] = q[(QUAD_LANES-1-i)*LANE_W +: LANE_W];
    return r;
  endfunction
endpackage

// File: rtl/qpack_cfg.sv
module qpack_cfg
  import qpack_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sop_i,
  input  logic             byte_mode_i,
  input  logic             swap_i,
  input  logic [SPD_W-1:0] speed_i,
  output logic             byte_eff_o,
  output logic             swap_eff_o,
  output logic             cfg_err_o
);
  logic byte_q, swap_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= 1'b0;
      swap_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (sop_i) begin
      byte_q <= byte_mode_i;
      swap_q <= swap_i;
      err_q  <= byte_mode_i && (speed_i > SPD_W'(BYTE_SPD_MAX));
    end
  end

  // controls presented with sop apply to a same-cycle fetch
  assign byte_eff_o = sop_i ? byte_mode_i : byte_q;
  assign swap_eff_o = sop_i ? swap_i      : swap_q;
  assign cfg_err_o  = err_q;
endmodule

// File: rtl/qpack_pack.sv
module qpack_pack
  import qpack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sop_i,
  input  logic              vld_i,
  input  logic [PORT_W-1:0] d_i,
  input  logic              byte_i,
  input  logic              swap_i,
  output logic [QUAD_W-1:0] quad_o,
  output logic              quad_vld_o
);
  localparam int unsigned ACC_W = QUAD_W - LANE_W;

  logic [CNT_W-1:0]  cnt_q, cnt_base;
  logic [ACC_W-1:0]  acc_q, acc_base;
  logic [QUAD_W-1:0] stacked;
  logic              last;

  assign cnt_base = sop_i ? '0 : cnt_q;
  assign acc_base = sop_i ? '0 : acc_q;
  assign last     = byte_i ? (cnt_base == CNT_W'(QUAD_LANES - 1))
                           : (cnt_base == CNT_W'(DBL_PER_QUAD - 1));
  assign stacked  = byte_i ? {acc_base, d_i[LANE_W-1:0]}
                           : {acc_base[PORT_W-1:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      acc_q      <= '0;
      quad_o     <= '0;
      quad_vld_o <= 1'b0;
    end else begin
      quad_vld_o <= 1'b0;
      if (vld_i) begin
        if (last) begin
          quad_o     <= swap_i ? lane_rev(stacked) : stacked;
          quad_vld_o <= 1'b1;
          cnt_q      <= '0;
          acc_q      <= '0;
        end else begin
          cnt_q <= cnt_base + 1'b1;
          acc_q <= stacked[ACC_W-1:0];
        end
      end else if (sop_i) begin
        cnt_q <= '0;
        acc_q <= '0;
      end
    end
  end
endmodule

// File: rtl/qpack_unpack.sv
module qpack_unpack
  import qpack_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [QUAD_W-1:0]     quad_i,
  input  logic                  byte_i,
  input  logic                  swap_i,
  output logic [PORT_W-1:0]     d_o,
  output logic [PORT_LANES-1:0] oe_o,
  output logic                  stb_o
);
  logic [QUAD_W-1:0] sreg_q;
  logic [REM_W-1:0]  rem_q;
  logic              ub_q, busy;

  assign busy = (rem_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      rem_q  <= '0;
      ub_q   <= 1'b0;
    end else if (!busy) begin
      if (load_i) begin
        sreg_q <= swap_i ? lane_rev(quad_i) : quad_i;
        rem_q  <= byte_i ? REM_W'(QUAD_LANES) : REM_W'(DBL_PER_QUAD);
        ub_q   <= byte_i;
      end
    end else begin
      sreg_q <= ub_q ? (sreg_q << LANE_W) : (sreg_q << PORT_W);
      rem_q  <= rem_q - 1'b1;
    end
  end

  assign stb_o = busy;

  for (genvar l = 0; l < PORT_LANES; l++) begin : g_lane
    if (l == 0) begin : g_low
      assign oe_o[l] = busy;
      assign d_o[LANE_W-1:0] = !busy ? '0
                             : ub_q  ? sreg_q[QUAD_W-1 -: LANE_W]
                                     : sreg_q[QUAD_W-PORT_W +: LANE_W];
    end else begin : g_up
      assign oe_o[l] = busy && !ub_q;
      assign d_o[l*LANE_W +: LANE_W] =
        oe_o[l] ? sreg_q[QUAD_W-PORT_W + l*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/qpack_top.sv
module qpack_top
  import qpack_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sop_i,
  input  logic                  byte_mode_i,
  input  logic                  swap_i,
  input  logic [SPD_W-1:0]      speed_i,
  input  logic [PORT_W-1:0]     port_d_i,
  input  logic                  port_vld_i,
  output logic [QUAD_W-1:0]     quad_o,
  output logic                  quad_vld_o,
  output logic                  cfg_err_o,
  input  logic [QUAD_W-1:0]     quad_i,
  input  logic                  quad_load_i,
  output logic [PORT_W-1:0]     port_d_o,
  output logic [PORT_LANES-1:0] port_oe_o,
  output logic                  port_stb_o
);
  logic byte_eff, swap_eff;

  qpack_cfg u_cfg (
    .clk_i, .rst_ni, .sop_i, .byte_mode_i, .swap_i, .speed_i,
    .byte_eff_o(byte_eff), .swap_eff_o(swap_eff), .cfg_err_o
  );

  qpack_pack u_pack (
    .clk_i, .rst_ni, .sop_i,
    .vld_i(port_vld_i), .d_i(port_d_i),
    .byte_i(byte_eff), .swap_i(swap_eff),
    .quad_o, .quad_vld_o
  );

  qpack_unpack u_unpack (
    .clk_i, .rst_ni,
    .load_i(quad_load_i), .quad_i,
    .byte_i(byte_eff), .swap_i(swap_eff),
    .d_o(port_d_o), .oe_o(port_oe_o), .stb_o(port_stb_o)
  );
endmodule

// File: rtl/qpack_chk.sv
module qpack_chk
  import qpack_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sop_i,
  input logic                  byte_mode_i,
  input logic [SPD_W-1:0]      speed_i,
  input logic                  port_vld_i,
  input logic                  quad_vld_o,
  input logic                  cfg_err_o,
  input logic [PORT_W-1:0]     port_d_o,
  input logic [PORT_LANES-1:0] port_oe_o
);
  assert_vld_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_vld_o |=> !quad_vld_o);

  assert_vld_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_vld_o |-> $past(port_vld_i));

  assert_cfg_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(sop_i) && $past(byte_mode_i) &&
     ($past(speed_i) > SPD_W'(BYTE_SPD_MAX))) |-> cfg_err_o);

  assert_upper_oe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_oe_o[1] |-> port_oe_o[0]);

  assert_upper_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_oe_o[1]) |-> (port_d_o[PORT_W-1:LANE_W] == '0));
endmodule

bind qpack_top qpack_chk u_chk (
  .clk_i, .rst_ni, .sop_i, .byte_mode_i, .speed_i, .port_vld_i,
  .quad_vld_o, .cfg_err_o, .port_d_o, .port_oe_o
);

// File: tb/qpack_top_tb_top.sv
module qpack_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sop = 1'b0, bm = 1'b0, sw = 1'b0;
  logic [1:0]  spd = 2'd0;
  logic [15:0] pd = '0;
  logic        pv = 1'b0;
  logic [31:0] q_o, q_i = '0;
  logic        qv, err, ld = 1'b0, stb;
  logic [15:0] pd_o;
  logic [1:0]  oe;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  qpack_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sop_i(sop), .byte_mode_i(bm), .swap_i(sw),
    .speed_i(spd), .port_d_i(pd), .port_vld_i(pv), .quad_o(q_o),
    .quad_vld_o(qv), .cfg_err_o(err), .quad_i(q_i), .quad_load_i(ld),
    .port_d_o(pd_o), .port_oe_o(oe), .port_stb_o(stb)
  );

  // {byte, swap, f0, f1, f2, f3, expected}
  localparam logic [97:0] VEC [6] = '{
    {1'b0, 1'b0, 16'hAB01, 16'hCD02, 16'h0, 16'h0, 32'hAB01CD02},
    {1'b0, 1'b1, 16'hAB01, 16'hCD02, 16'h0, 16'h0, 32'h02CD01AB},
    {1'b1, 1'b0, 16'hFFAB, 16'hEE01, 16'h77CD, 16'h1102, 32'hAB01CD02},
    {1'b1, 1'b1, 16'hFFAB, 16'hEE01, 16'h77CD, 16'h1102, 32'h02CD01AB},
    {1'b0, 1'b0, 16'h1234, 16'h5678, 16'h0, 16'h0, 32'h12345678},
    {1'b1, 1'b1, 16'h00DE, 16'h00AD, 16'h00BE, 16'h00EF, 32'hEFBEADDE}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start(logic b, logic s, logic [1:0] sp);
    bm = b; sw = s; spd = sp; sop = 1'b1;
    tick();
    sop = 1'b0;
  endtask

  task automatic fetch(logic [15:0] d);
    pd = d; pv = 1'b1;
    tick();
    pv = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11 quad", q_o, 0);
    check("R11 vld/err/stb", {qv, err, stb}, 0);
    check("R11 oe/data", {oe, pd_o}, 0);
    rst_n = 1'b1;
    tick();
    check("R11 after release", {q_o, qv, err, stb, oe, pd_o}, 0);

    // R1 R2 R3 table walk
    for (int i = 0; i < 6; i++) begin
      start(VEC[i][97], VEC[i][96], 2'd0);
      fetch(VEC[i][95:80]);
      check("R4 no early pulse", qv, 0);
      fetch(VEC[i][79:64]);
      if (VEC[i][97]) begin
        fetch(VEC[i][63:48]);
        fetch(VEC[i][47:32]);
      end
      check("R1/R2/R3 quad", q_o, VEC[i][31:0]);
      check("R4 pulse", qv, 1);
      tick();
      check("R4 pulse ends", qv, 0);
      check("R4 quad held", q_o, VEC[i][31:0]);
    end

    // R5 sop with fetch mid-quadlet
    start(1'b0, 1'b0, 2'd0);
    fetch(16'hAAAA);
    bm = 1'b1; sw = 1'b1; sop = 1'b1; pd = 16'h0011; pv = 1'b1;
    tick();
    sop = 1'b0; pv = 1'b0;
    check("R5 no pulse on sop+fetch", qv, 0);
    fetch(16'h0022); fetch(16'h0033); fetch(16'h0044);
    check("R5 restarted quad", q_o, 32'h44332211);

    // R6 mid-packet control change ignored
    start(1'b0, 1'b0, 2'd0);
    fetch(16'h1234);
    bm = 1'b1; sw = 1'b1;
    fetch(16'h5678);
    check("R6 vld", qv, 1);
    check("R6 quad", q_o, 32'h12345678);

    // R7 speed check
    start(1'b1, 1'b0, 2'd2);
    check("R7 byte fast", err, 1);
    start(1'b1, 1'b0, 2'd1);
    check("R7 byte slow", err, 0);
    start(1'b0, 1'b0, 2'd3);
    check("R7 doublet fast", err, 0);

    // R8 R9 doublet unpack
    start(1'b0, 1'b0, 2'd0);
    q_i = 32'hAB01CD02; ld = 1'b1;
    tick();
    ld = 1'b0;
    check("R8 dbl first", {stb, pd_o}, {1'b1, 16'hAB01});
    check("R9 dbl oe", oe, 2'b11);
    tick();
    check("R8 dbl second", {stb, pd_o}, {1'b1, 16'hCD02});
    tick();
    check("R9 idle", {stb, oe, pd_o}, 0);

    // R8 R9 R10 byte unpack with swap, load while busy
    start(1'b1, 1'b1, 2'd0);
    q_i = 32'h02CD01AB; ld = 1'b1;
    tick();
    check("R8 byte 0", {stb, pd_o}, {1'b1, 16'h00AB});
    check("R9 byte oe", oe, 2'b01);
    q_i = 32'hDEADBEEF;
    tick();
    ld = 1'b0;
    check("R10 byte 1", pd_o, 16'h0001);
    tick();
    check("R10 byte 2", pd_o, 16'h00CD);
    tick();
    check("R8 byte 3", {stb, oe, pd_o}, {1'b1, 2'b01, 16'h0002});
    tick();
    check("R8 done", {stb, oe, pd_o}, 0);

    finish_run();
  end
endmodule